// File: doc/BRIEF.md
# Erase-and-Verify Sequencer for a Serial Flash Programming Port

This block is the host side of a serial programming link. On a start request it runs a complete, checked erase of a target memory over a clock/data/output-enable link. First it writes zero to every location in a configured address window through a simple request/acknowledge port that stands in for the byte-write command. Then it sends the two-byte erase command and waits out the target's busy period. After that it reads back every address with the erase-verify command.

A location counts as erased when it reads all ones. The first location that does not read erased starts a new erase. The zero pre-write is not repeated on these retries. The run ends with `done` once a full verify pass succeeds. It ends with `fail` when a parameterised number of erases has been spent without a clean pass. The serial clock half-period and the output-enable pulse width are parameters counted in system clocks.

Top module: `sb_erase_seq`

## Requirements
- R1: After reset and before any start, `sclk` is low, `oe_n` is high, `sda_oe`, `wr_req`, `done` and `fail` are low.
- R2: On `start`, `wr_req` is raised once for each address from `FIRST` up to `LAST` in ascending order, advancing on each `wr_ack`. `wr_addr` holds steady while a request waits. No serial clocking happens until all writes are acknowledged.
- R3: Every erase is the byte 0x20 sent twice. Each byte is 8 bits, least-significant bit first, and is valid on `sda_out` while `sclk` is high. The sequencer then waits for `busy` to go high and then low, and produces no `sclk` edge meanwhile.
- R4: After every erase, each address is verified in ascending order from `FIRST`. A verify sends 0xA0, the low address byte and the high address byte, each LSB first. It then drives `oe_n` low for exactly `OE_W` clocks with `sclk` low and `sda_oe` low, then clocks 8 bits in on `sda_in` with `sda_oe` low.
- R5: A received byte other than 0xFF stops the pass and starts another erase (R3). The zero pre-write of R2 is not repeated.
- R6: When every address in the window reads 0xFF in one pass, `done` goes high. It stays high until the next `start`.
- R7: If the pass after erase number `MAX_ERASE` still finds a non-0xFF byte, `fail` goes high and no further erase is sent. `done` and `fail` are never both high.
- R8: Received bits are sampled at each `sclk` rising edge and assembled LSB first.
- R9: Each `sclk` high phase and low phase lasts `SCLK_HALF` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a full erase run |
| busy | input | 1 | Target busy flag during erase |
| sda_in | input | 1 | Serial data from target |
| wr_ack | input | 1 | Zero-write accepted for `wr_addr` |
| sclk | output | 1 | Serial clock to target |
| sda_out | output | 1 | Serial data to target |
| sda_oe | output | 1 | High while the host drives the data line |
| oe_n | output | 1 | Active-low read strobe to target |
| wr_req | output | 1 | Zero-write request |
| wr_addr | output | 16 | Address of the requested zero-write |
| done | output | 1 | Erase verified over the whole window |
| fail | output | 1 | Erase limit reached without a clean pass |

## Verification
The hardest paths to reach are the retry loop near its ends. Examples are a location that stays unerased until exactly the last allowed erase, an unerased first or last address, and a run that runs out of erases. A bench model of the target is set up for each run with, per address, the number of erases that address needs before it reads 0xFF. This makes every pass length and retry count a set choice, and the bench works out the expected sequence of verified addresses. The model also decodes every byte sent, checks the erase and verify command framing, and counts pre-writes across retries.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int unsigned ADDR_W = 16;

    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_VERIFY = 8'hA0;
    localparam logic [7:0] BLANK_BYTE = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ZERO,
        ST_ER_A,
        ST_ER_B,
        ST_BUSY_HI,
        ST_BUSY_LO,
        ST_VF_CMD,
        ST_VF_LO,
        ST_VF_HI,
        ST_STROBE,
        ST_READ,
        ST_JUDGE
    } seq_st_e;
endpackage

// File: rtl/sb_shift.sv
module sb_shift #(
    parameter int unsigned SCLK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       rx_mode,
    input  logic [7:0] tx_byte,
    input  logic       sda_in,
    output logic       fin,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       sda_out,
    output logic       sda_oe
);
    localparam int unsigned CW = (SCLK_HALF < 2) ? 1 : $clog2(SCLK_HALF);

    typedef struct packed {
        logic          act;
        logic          hi;
        logic          rx;
        logic [CW-1:0] cnt;
        logic [2:0]    bitn;
        logic [7:0]    sh;
        logic          clk_o;
        logic          fin;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        if (!q.act) begin
            if (go) begin
                d.act   = 1'b1;
                d.hi    = 1'b0;
                d.rx    = rx_mode;
                d.cnt   = '0;
                d.bitn  = '0;
                d.sh    = rx_mode ? 8'h00 : tx_byte;
                d.clk_o = 1'b0;
            end
        end else if (!q.hi) begin
            if (q.cnt == CW'(SCLK_HALF - 1)) begin
                d.hi    = 1'b1;
                d.cnt   = '0;
                d.clk_o = 1'b1;
                if (q.rx) begin
                    d.sh = {sda_in, q.sh[7:1]};
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            if (q.cnt == CW'(SCLK_HALF - 1)) begin
                d.hi    = 1'b0;
                d.cnt   = '0;
                d.clk_o = 1'b0;
                if (q.bitn == 3'd7) begin
                    d.act = 1'b0;
                    d.fin = 1'b1;
                end else begin
                    d.bitn = q.bitn + 1'b1;
                    if (!q.rx) begin
                        d.sh = {1'b0, q.sh[7:1]};
                    end
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign fin     = q.fin;
    assign rx_byte = q.sh;
    assign sclk    = q.clk_o;
    assign sda_oe  = q.act && !q.rx;
    assign sda_out = sda_oe ? q.sh[0] : 1'b0;
endmodule

// File: rtl/sb_seq.sv
module sb_seq
    import sb_pkg::*;
#(
    parameter int unsigned FIRST     = 0,
    parameter int unsigned LAST      = 15,
    parameter int unsigned MAX_ERASE = 4,
    parameter int unsigned OE_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              busy,
    input  logic              wr_ack,
    input  logic              sh_fin,
    input  logic [7:0]        sh_rx_byte,
    output logic              sh_go,
    output logic              sh_rx,
    output logic [7:0]        sh_byte,
    output logic              oe_n,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              done,
    output logic              fail
);
    localparam int unsigned EW = $clog2(MAX_ERASE + 1);
    localparam int unsigned OW = (OE_W < 2) ? 1 : $clog2(OE_W);
    localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(FIRST);
    localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(LAST);

    typedef struct packed {
        seq_st_e           st;
        logic [ADDR_W-1:0] addr;
        logic [EW-1:0]     erases;
        logic [OW-1:0]     ocnt;
        logic              issued;
        logic [7:0]        data;
        logic              done;
        logic              fail;
    } seq_t;

    seq_t q, d;

    logic serial_st;

    always_comb begin
        serial_st = (q.st == ST_ER_A) || (q.st == ST_ER_B) ||
                    (q.st == ST_VF_CMD) || (q.st == ST_VF_LO) ||
                    (q.st == ST_VF_HI) || (q.st == ST_READ);
        sh_go = serial_st && !q.issued;
        sh_rx = (q.st == ST_READ);
        unique case (q.st)
            ST_ER_A, ST_ER_B: sh_byte = CMD_ERASE;
            ST_VF_CMD:        sh_byte = CMD_VERIFY;
            ST_VF_LO:         sh_byte = q.addr[7:0];
            ST_VF_HI:         sh_byte = q.addr[15:8];
            default:          sh_byte = 8'h00;
        endcase
    end

    always_comb begin
        d = q;
        if (serial_st && !q.issued) begin
            d.issued = 1'b1;
        end
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st     = ST_ZERO;
                    d.addr   = A_FIRST;
                    d.erases = '0;
                    d.done   = 1'b0;
                    d.fail   = 1'b0;
                end
            end
            ST_ZERO: begin
                if (wr_ack) begin
                    if (q.addr == A_LAST) begin
                        d.st = ST_ER_A;
                    end else begin
                        d.addr = q.addr + 1'b1;
                    end
                end
            end
            ST_ER_A: begin
                if (q.issued && sh_fin) begin
                    d.issued = 1'b0;
                    d.st     = ST_ER_B;
                end
            end
            ST_ER_B: begin
                if (q.issued && sh_fin) begin
                    d.issued = 1'b0;
                    d.erases = q.erases + 1'b1;
                    d.st     = ST_BUSY_HI;
                end
            end
            ST_BUSY_HI: begin
                if (busy) begin
                    d.st = ST_BUSY_LO;
                end
            end
            ST_BUSY_LO: begin
                if (!busy) begin
                    d.addr = A_FIRST;
                    d.st   = ST_VF_CMD;
                end
            end
            ST_VF_CMD: begin
                if (q.issued && sh_fin) begin
                    d.issued = 1'b0;
                    d.st     = ST_VF_LO;
                end
            end
            ST_VF_LO: begin
                if (q.issued && sh_fin) begin
                    d.issued = 1'b0;
                    d.st     = ST_VF_HI;
                end
            end
            ST_VF_HI: begin
                if (q.issued && sh_fin) begin
                    d.issued = 1'b0;
                    d.ocnt   = '0;
                    d.st     = ST_STROBE;
                end
            end
            ST_STROBE: begin
                if (q.ocnt == OW'(OE_W - 1)) begin
                    d.st = ST_READ;
                end else begin
                    d.ocnt = q.ocnt + 1'b1;
                end
            end
            ST_READ: begin
                if (q.issued && sh_fin) begin
                    d.issued = 1'b0;
                    d.data   = sh_rx_byte;
                    d.st     = ST_JUDGE;
                end
            end
            ST_JUDGE: begin
                if (q.data == BLANK_BYTE) begin
                    if (q.addr == A_LAST) begin
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.addr = q.addr + 1'b1;
                        d.st   = ST_VF_CMD;
                    end
                end else if (q.erases == EW'(MAX_ERASE)) begin
                    d.fail = 1'b1;
                    d.st   = ST_IDLE;
                end else begin
                    d.st = ST_ER_A;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign oe_n    = (q.st != ST_STROBE);
    assign wr_req  = (q.st == ST_ZERO);
    assign wr_addr = q.addr;
    assign done    = q.done;
    assign fail    = q.fail;
endmodule

// File: rtl/sb_erase_seq.sv
module sb_erase_seq #(
    parameter int unsigned FIRST     = 0,
    parameter int unsigned LAST      = 15,
    parameter int unsigned MAX_ERASE = 4,
    parameter int unsigned SCLK_HALF = 2,
    parameter int unsigned OE_W      = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        busy,
    input  logic        sda_in,
    input  logic        wr_ack,
    output logic        sclk,
    output logic        sda_out,
    output logic        sda_oe,
    output logic        oe_n,
    output logic        wr_req,
    output logic [15:0] wr_addr,
    output logic        done,
    output logic        fail
);
    logic       sh_go;
    logic       sh_rx;
    logic [7:0] sh_byte;
    logic       sh_fin;
    logic [7:0] sh_rx_byte;

    sb_seq #(
        .FIRST    (FIRST),
        .LAST     (LAST),
        .MAX_ERASE(MAX_ERASE),
        .OE_W     (OE_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .busy      (busy),
        .wr_ack    (wr_ack),
        .sh_fin    (sh_fin),
        .sh_rx_byte(sh_rx_byte),
        .sh_go     (sh_go),
        .sh_rx     (sh_rx),
        .sh_byte   (sh_byte),
        .oe_n      (oe_n),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .done      (done),
        .fail      (fail)
    );

    sb_shift #(
        .SCLK_HALF(SCLK_HALF)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (sh_go),
        .rx_mode(sh_rx),
        .tx_byte(sh_byte),
        .sda_in (sda_in),
        .fin    (sh_fin),
        .rx_byte(sh_rx_byte),
        .sclk   (sclk),
        .sda_out(sda_out),
        .sda_oe (sda_oe)
    );
endmodule

// File: rtl/sb_erase_seq_chk.sv
module sb_erase_seq_chk #(
    parameter int unsigned OE_W = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        wr_ack,
    input logic        sclk,
    input logic        sda_out,
    input logic        sda_oe,
    input logic        oe_n,
    input logic        wr_req,
    input logic [15:0] wr_addr,
    input logic        done,
    input logic        fail
);
    logic [7:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!oe_n) begin
            low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sclk && oe_n && !sda_oe && !wr_req && !done && !fail)); // R1

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr))); // R2

    AST_WR_NO_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (!sclk && !sda_oe && oe_n)); // R2

    AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk) && sda_oe && $past(sda_oe)) |-> $stable(sda_out)); // R3

    AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!sclk && !sda_oe)); // R4

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> (low_cnt == 8'(OE_W))); // R4

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R6

    AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail)); // R7
endmodule

bind sb_erase_seq sb_erase_seq_chk #(.OE_W(OE_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .wr_ack (wr_ack),
    .sclk   (sclk),
    .sda_out(sda_out),
    .sda_oe (sda_oe),
    .oe_n   (oe_n),
    .wr_req (wr_req),
    .wr_addr(wr_addr),
    .done   (done),
    .fail   (fail)
);

// File: tb/sim_sb_erase_seq.sv
`timescale 1ns/1ps
module sim_sb_erase_seq;
    localparam int FIRST = 0;
    localparam int LAST  = 15;
    localparam int NADDR = LAST - FIRST + 1;
    localparam int MAXE  = 4;
    localparam int HALF  = 2;
    localparam int OEW   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy = 1'b0;
    logic sda_in = 1'b0;
    logic wr_ack = 1'b0;
    logic sclk, sda_out, sda_oe, oe_n, wr_req, done, fail;
    logic [15:0] wr_addr;

    always #2 clk = ~clk;

    sb_erase_seq #(.FIRST(FIRST), .LAST(LAST), .MAX_ERASE(MAXE),
                   .SCLK_HALF(HALF), .OE_W(OEW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .sda_in(sda_in),
        .wr_ack(wr_ack), .sclk(sclk), .sda_out(sda_out), .sda_oe(sda_oe),
        .oe_n(oe_n), .wr_req(wr_req), .wr_addr(wr_addr), .done(done), .fail(fail));

    int vectors = 0;
    int errors = 0;

    task automatic check(input string req, input logic ok, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // target model state
    int need [NADDR];
    int erases, wr_cnt, wr_order_err, pre_err, bad_cmd, vcnt, busy_edges, width_err;
    int vlog [256];
    int phase, nb, ridx;
    logic [7:0] shreg, lo, rdata;
    logic armed = 1'b0, rxm = 1'b0;
    time t_rise;
    event erase_ev;

    always @(negedge clk) begin
        if (wr_ack) begin
            wr_ack = 1'b0;
        end else if (wr_req) begin
            if (int'(wr_addr) != FIRST + wr_cnt) wr_order_err++;
            wr_cnt++;
            wr_ack = 1'b1;
        end
    end

    always @(posedge sclk) begin
        t_rise = $time;
        if (busy) busy_edges++;
        if (rxm) begin
            ridx++;
            if (ridx == 8) begin
                rxm = 1'b0;
            end else begin
                #1 sda_in = rdata[ridx];
            end
        end else if (sda_oe) begin
            shreg = {sda_out, shreg[7:1]};
            nb++;
            if (nb == 8) begin
                nb = 0;
                case (phase)
                    0: if (shreg == 8'h20) phase = 1;
                       else if (shreg == 8'hA0) phase = 2;
                       else bad_cmd++;
                    1: begin
                        if (shreg == 8'h20) begin
                            erases++;
                            if (wr_cnt != NADDR) pre_err++;
                            -> erase_ev;
                        end else bad_cmd++;
                        phase = 0;
                    end
                    2: begin lo = shreg; phase = 3; end
                    default: begin
                        if (vcnt < 256) vlog[vcnt] = int'({shreg, lo});
                        vcnt++;
                        armed = 1'b1;
                        phase = 0;
                    end
                endcase
            end
        end
    end

    always @(negedge sclk) begin
        if (($time - t_rise) != HALF * 4) width_err++;
    end

    always @(posedge oe_n) begin
        if (armed) begin
            int a;
            armed = 1'b0;
            a = (vcnt > 0 && vcnt <= 256) ? vlog[vcnt-1] - FIRST : 0;
            rdata = (a >= 0 && a < NADDR && erases >= need[a]) ? 8'hFF : 8'hFE;
            rxm = 1'b1;
            ridx = 0;
            sda_in = rdata[0];
        end
    end

    always begin
        @(erase_ev);
        #40 busy = 1'b1;
        #400 busy = 1'b0;
    end

    task automatic run(input string name, input int bad_addr, input int bad_need);
        int exp_e, exp_v;
        logic exp_done;
        int elist [256];
        int cyc;
        for (int a = 0; a < NADDR; a++) need[a] = 1;
        if (bad_addr >= 0) need[bad_addr] = bad_need;
        erases = 0; wr_cnt = 0; wr_order_err = 0; pre_err = 0; bad_cmd = 0;
        vcnt = 0; busy_edges = 0; width_err = 0; phase = 0; nb = 0;
        // expected trace
        exp_v = 0; exp_done = 1'b0; exp_e = MAXE;
        for (int e = 1; e <= MAXE && !exp_done; e++) begin
            logic bad;
            bad = 1'b0;
            for (int a = 0; a < NADDR && !bad; a++) begin
                elist[exp_v] = FIRST + a;
                exp_v++;
                if (need[a] > e) bad = 1'b1;
            end
            if (!bad) begin exp_done = 1'b1; exp_e = e; end
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0;
        while (!(done || fail) && cyc < 60000) begin
            @(negedge clk); cyc++;
        end
        check({name, " R6/R7 finish"}, cyc < 60000, cyc, 60000);
        check({name, " R6 done"}, done == exp_done, done, exp_done);
        check({name, " R7 fail"}, fail == !exp_done, fail, !exp_done);
        check({name, " R5 erase count"}, erases == exp_e, erases, exp_e);
        check({name, " R2 prewrite once"}, wr_cnt == NADDR, wr_cnt, NADDR);
        check({name, " R2 order"}, wr_order_err == 0, wr_order_err, 0);
        check({name, " R2 before erase"}, pre_err == 0, pre_err, 0);
        check({name, " R3 command bytes"}, bad_cmd == 0, bad_cmd, 0);
        check({name, " R3 no clock while busy"}, busy_edges == 0, busy_edges, 0);
        check({name, " R4 verify count"}, vcnt == exp_v, vcnt, exp_v);
        begin
            int mism;
            mism = -1;
            for (int i = 0; i < exp_v && i < vcnt; i++)
                if (mism < 0 && vlog[i] != elist[i]) mism = i;
            check({name, " R4 verify order"}, mism < 0,
                  (mism < 0) ? 0 : vlog[mism], (mism < 0) ? 0 : elist[mism]);
        end
        check({name, " R9 sclk half period"}, width_err == 0, width_err, 0);
        repeat (50) @(negedge clk);
        check({name, " R6 sticky"}, done == exp_done && fail == !exp_done, done, exp_done);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 sclk", sclk == 1'b0, sclk, 0);
        check("R1 oe_n", oe_n == 1'b1, oe_n, 1);
        check("R1 idle", {sda_oe, wr_req, done, fail} == 4'b0, {sda_oe, wr_req, done, fail}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 after release", {sclk, wr_req, done, fail} == 4'b0, {sclk, wr_req, done, fail}, 0);
        run("clean", -1, 1);
        run("last addr R5", NADDR - 1, 2);
        run("first addr R5 R8", 0, 3);
        run("limit exact R5", 7, MAXE);
        run("exhaust R7", 9, MAXE + 1);
        run("restart R2", -1, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(4 * 190000);
        errors++;
        vectors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule